// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a small device. It runs entirely on the test clock and is independent of the system clock, so the test clock may run faster than the system clock. A standard sixteen-state controller follows the mode-select line, and a 4-bit instruction register steers one of four data registers between the serial input and the serial output. The four data registers are a one-bit bypass register, a 32-bit identification register, a one-bit device-reset register, and a scan chain of three cells per digital pin.

A board tester uses the block to observe pin levels, force pin drivers and output enables, read the identification code and hold the device in reset. The port works only while the fuse input is programmed and the disable control bit is clear. Otherwise the serial output is released and the controller is held in its reset state.

Top module: `jtag_bscan_tap`

## Requirements
- R1: After the controller has passed through Test-Logic-Reset, the active instruction is IDCODE (`0001`), and a data scan shifts out the identification word LSB first. Bit 0 of that word is always 1, whatever the parameter holds.
- R2: Capture-IR loads `0001`, which is shifted out LSB first during Shift-IR. A new instruction takes effect only on the clock edge that leaves Update-IR.
- R3: BYPASS (`1111`) and every unsupported opcode (for example `0101`) place a single cell between input and output. That cell captures 0, so the output of a data scan is the input delayed by one bit.
- R4: SAMPLE/PRELOAD (`0010`) captures, for pin i, the pin level into chain bit 3i, the system output value into bit 3i+1 and the system output enable into bit 3i+2. Bit 0 is nearest the serial output. Under this instruction the pins keep their system-driven values.
- R5: EXTEST (`0000`) drives each pin from the update latches of its output-data cell (3i+1) and output-enable cell (3i+2). This starts on the edge that leaves Update-IR, with no extra data update. A later data update under EXTEST changes the pins, and its capture returns the pin levels.
- R6: Under the reset instruction (`1100`), updating a 1 into the one-bit reset register raises `sys_rst_req`. The request stays high across other instructions and across Test-Logic-Reset until a 0 is updated. A capture of this register returns its current value.
- R7: While `sys_rst_req` or `ext_reset` is high and EXTEST is not active, every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R8: The port is enabled only when `fuse_prog` is 1 and `jtag_dis` is 0. While it is disabled, `tdo_oe` is 0, the controller stays in Test-Logic-Reset, and the reset register and update latches clear.
- R9: TDO and its enable change only on the falling edge of the test clock. The enable is high only while the controller is in Shift-IR or Shift-DR.
- R10: Five consecutive rising edges with TMS high bring the controller to Test-Logic-Reset from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| fuse_prog | input | 1 | Fuse programmed (1 allows the port) |
| jtag_dis | input | 1 | Disable control bit (1 turns the port off) |
| ext_reset | input | 1 | External system reset is active |
| pin_in | input | NPINS | Levels observed at the pins |
| sys_pin_out | input | NPINS | Output values from system logic |
| sys_pin_oe | input | NPINS | Output enables from system logic |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Drive enable for tdo |
| pin_out | output | NPINS | Value driven to the pins |
| pin_oe | output | NPINS | Output enable driven to the pins |
| sys_rst_req | output | 1 | Request holding the device in reset |

## Verification
The bench builds the block with six pins, which gives an 18-cell chain short enough to preload and compare in full. It also uses an identification parameter whose bit 0 is clear, so the forced-one rule of R1 is visible. Together these bring into reach the per-pin cell order, the immediate takeover of the pins by EXTEST, and the reset request that outlives instruction changes. They also cover the one-bit delay of unsupported opcodes and the falling-edge timing of TDO.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;

    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSC, DR_RST} dr_sel_e;

    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } scan_ctl_t;

    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_SYSRST  = 4'b1100;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            TLR:     return m ? TLR    : RTI;
            RTI:     return m ? SEL_DR : RTI;
            SEL_DR:  return m ? SEL_IR : CAP_DR;
            CAP_DR:  return m ? EX1_DR : SHF_DR;
            SHF_DR:  return m ? EX1_DR : SHF_DR;
            EX1_DR:  return m ? UPD_DR : PAU_DR;
            PAU_DR:  return m ? EX2_DR : PAU_DR;
            EX2_DR:  return m ? UPD_DR : SHF_DR;
            UPD_DR:  return m ? SEL_DR : RTI;
            SEL_IR:  return m ? TLR    : CAP_IR;
            CAP_IR:  return m ? EX1_IR : SHF_IR;
            SHF_IR:  return m ? EX1_IR : SHF_IR;
            EX1_IR:  return m ? UPD_IR : PAU_IR;
            PAU_IR:  return m ? EX2_IR : PAU_IR;
            EX2_IR:  return m ? UPD_IR : SHF_IR;
            default: return m ? SEL_DR : RTI;
        endcase
    endfunction

    function automatic dr_sel_e ir_decode(input logic [IR_W-1:0] op);
        case (op)
            OP_IDCODE:             return DR_ID;
            OP_EXTEST, OP_SAMPLE:  return DR_BSC;
            OP_SYSRST:             return DR_RST;
            default:               return DR_BYP;
        endcase
    endfunction

    function automatic scan_ctl_t dr_ctl(input tap_state_e s, input logic sel);
        scan_ctl_t c;
        c.capture = sel && (s == CAP_DR);
        c.shift   = sel && (s == SHF_DR);
        c.update  = sel && (s == UPD_DR);
        return c;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       port_en,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (!port_en) state <= TLR;
        else          state <= tap_next(state, tms);
    end

    assert_five_ones_tlr_R10: assert property (@(posedge tck) disable iff (!port_en)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == TLR));

    assert_disabled_tlr_R8: assert property (@(posedge tck)
        !port_en |=> (state == TLR));

endmodule

// File: rtl/jtag_ir_reg.sv
module jtag_ir_reg
    import jtag_bscan_pkg::*;
(
    input  logic            tck,
    input  logic            port_en,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (!port_en) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == CAP_IR) begin
            ir_sr <= IR_CAPTURE;
        end else if (state == SHF_IR) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (!port_en || state == TLR) ir_q <= OP_IDCODE;
        else if (state == UPD_IR)     ir_q <= ir_sr;
    end

    assign ir_so = ir_sr[0];

    assert_ir_only_update_R2: assert property (@(posedge tck) disable iff (!port_en)
        (state != UPD_IR && state != TLR) |=> $stable(ir_q));

    assert_tlr_idcode_R1: assert property (@(posedge tck) disable iff (!port_en)
        (state == TLR) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/jtag_bscan_chain.sv
module jtag_bscan_chain
    import jtag_bscan_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             tck,
    input  logic             port_en,
    input  scan_ctl_t        ctl,
    input  logic             tdi,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] sys_out,
    input  logic [NPINS-1:0] sys_oe,
    output logic             chain_so,
    output logic [NPINS-1:0] upd_out,
    output logic [NPINS-1:0] upd_oe
);

    localparam int CELLS = 3 * NPINS;

    logic [CELLS-1:0] cap_vec;
    logic [CELLS-1:0] sr;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign cap_vec[3*i]   = pin_in[i];
        assign cap_vec[3*i+1] = sys_out[i];
        assign cap_vec[3*i+2] = sys_oe[i];

        always_ff @(posedge tck) begin
            if (!port_en) begin
                upd_out[i] <= 1'b0;
                upd_oe[i]  <= 1'b0;
            end else if (ctl.update) begin
                upd_out[i] <= sr[3*i+1];
                upd_oe[i]  <= sr[3*i+2];
            end
        end
    end

    always_ff @(posedge tck) begin
        if (ctl.capture)    sr <= cap_vec;
        else if (ctl.shift) sr <= {tdi, sr[CELLS-1:1]};
    end

    assign chain_so = sr[0];

    assert_latch_hold_R5: assert property (@(posedge tck) disable iff (!port_en)
        !ctl.update |=> ($stable(upd_out) && $stable(upd_oe)));

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
    import jtag_bscan_pkg::*;
#(
    parameter int          NPINS      = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h3B1C_905F
) (
    input  logic             tck,
    input  logic             tms,
    input  logic             tdi,
    input  logic             fuse_prog,
    input  logic             jtag_dis,
    input  logic             ext_reset,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] sys_pin_out,
    input  logic [NPINS-1:0] sys_pin_oe,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             sys_rst_req
);

    localparam int          ID_W    = 32;
    localparam logic [ID_W-1:0] ID_WORD = {IDCODE_VAL[ID_W-1:1], 1'b1};

    logic            port_en;
    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_so;
    dr_sel_e         sel;
    scan_ctl_t       bsc_ctl;
    logic            bsc_so;
    logic [NPINS-1:0] upd_out, upd_oe;
    logic            byp_q;
    logic [ID_W-1:0] id_sr;
    logic            rst_sr, rst_q;
    logic            so_mux;
    logic            sys_in_reset;

    assign port_en = fuse_prog && !jtag_dis;
    assign sel     = ir_decode(ir_q);
    assign bsc_ctl = dr_ctl(state, sel == DR_BSC);

    jtag_tap_fsm u_fsm (
        .tck(tck), .port_en(port_en), .tms(tms), .state(state)
    );

    jtag_ir_reg u_ir (
        .tck(tck), .port_en(port_en), .state(state), .tdi(tdi),
        .ir_q(ir_q), .ir_so(ir_so)
    );

    jtag_bscan_chain #(.NPINS(NPINS)) u_chain (
        .tck(tck), .port_en(port_en), .ctl(bsc_ctl), .tdi(tdi),
        .pin_in(pin_in), .sys_out(sys_pin_out), .sys_oe(sys_pin_oe),
        .chain_so(bsc_so), .upd_out(upd_out), .upd_oe(upd_oe)
    );

    // bypass, identification and reset data registers
    always_ff @(posedge tck) begin
        if (state == CAP_DR) begin
            byp_q  <= 1'b0;
            id_sr  <= ID_WORD;
            rst_sr <= rst_q;
        end else if (state == SHF_DR) begin
            byp_q  <= tdi;
            id_sr  <= {tdi, id_sr[ID_W-1:1]};
            rst_sr <= tdi;
        end
    end

    always_ff @(posedge tck) begin
        if (!port_en)                              rst_q <= 1'b0;
        else if (state == UPD_DR && sel == DR_RST) rst_q <= rst_sr;
    end

    assign sys_rst_req = rst_q;

    always_comb begin
        if (state == SHF_IR) begin
            so_mux = ir_so;
        end else begin
            case (sel)
                DR_ID:   so_mux = id_sr[0];
                DR_BSC:  so_mux = bsc_so;
                DR_RST:  so_mux = rst_sr;
                default: so_mux = byp_q;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (!port_en) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= so_mux;
            tdo_oe <= (state == SHF_IR) || (state == SHF_DR);
        end
    end

    assign sys_in_reset = rst_q || ext_reset;

    always_comb begin
        if (ir_q == OP_EXTEST) begin
            pin_out = upd_out;
            pin_oe  = upd_oe;
        end else if (sys_in_reset) begin
            pin_out = '0;
            pin_oe  = '0;
        end else begin
            pin_out = sys_pin_out;
            pin_oe  = sys_pin_oe;
        end
    end

    assert_tdo_oe_shift_R9: assert property (@(posedge tck) disable iff (!port_en)
        tdo_oe == (state == SHF_IR || state == SHF_DR));

    assert_rst_hold_R6: assert property (@(posedge tck) disable iff (!port_en)
        !(state == UPD_DR && sel == DR_RST) |=> $stable(rst_q));

    assert_reset_hiz_R7: assert property (@(posedge tck) disable iff (!port_en)
        (sys_in_reset && ir_q != OP_EXTEST) |-> (pin_oe == '0));

    assert_bypass_zero_R3: assert property (@(posedge tck) disable iff (!port_en)
        (state == CAP_DR && sel == DR_BYP) |=> !byp_q);

endmodule

// File: tb/jtag_bscan_tap_test.sv
`timescale 1ns/100ps
module jtag_bscan_tap_test;
    localparam int          NP   = 6;
    localparam int          CH   = 3 * NP;
    localparam logic [31:0] IDV  = 32'h5A3C_96E4;
    localparam logic [31:0] IDX  = {IDV[31:1], 1'b1};

    logic tck = 1'b0;
    logic tms = 1'b1, tdi = 1'b0;
    logic fuse_prog = 1'b1, jtag_dis = 1'b1, ext_reset = 1'b0;
    logic [NP-1:0] pin_in = '0, sys_pin_out = '0, sys_pin_oe = '0;
    logic tdo, tdo_oe, sys_rst_req;
    logic [NP-1:0] pin_out, pin_oe;

    int checks = 0, errors = 0;

    always #2.5 tck = ~tck;

    jtag_bscan_tap #(.NPINS(NP), .IDCODE_VAL(IDV)) uut (
        .tck(tck), .tms(tms), .tdi(tdi), .fuse_prog(fuse_prog), .jtag_dis(jtag_dis),
        .ext_reset(ext_reset), .pin_in(pin_in), .sys_pin_out(sys_pin_out),
        .sys_pin_oe(sys_pin_oe), .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out),
        .pin_oe(pin_oe), .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo; tms = m; tdi = d;
        @(posedge tck);
    endtask

    task automatic go_tlr_rti();
        logic x;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, x);
        tick(1'b0, 1'b0, x);
    endtask

    task automatic scan_ir(input logic [3:0] v, output logic [3:0] o);
        logic x;
        tick(1, 0, x); tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, v[i], x);
            o[i] = x;
        end
        tick(1, 0, x); tick(0, 0, x);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] v, output logic [63:0] o);
        logic x;
        o = '0;
        tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, v[i], x);
            o[i] = x;
        end
        tick(1, 0, x); tick(0, 0, x);
    endtask

    task automatic t_reset_state();
        sys_pin_out = 6'b101100; sys_pin_oe = 6'b111000;
        repeat (4) @(posedge tck);
        #1;
        chk(tdo_oe == 1'b0, "R8 disabled tdo_oe", 64'(tdo_oe), 0);
        chk(sys_rst_req == 1'b0, "R8 disabled reset req", 64'(sys_rst_req), 0);
        chk(pin_out == sys_pin_out && pin_oe == sys_pin_oe, "R7 pass-through at reset",
            64'({pin_out, pin_oe}), 64'({sys_pin_out, sys_pin_oe}));
        jtag_dis = 1'b0;
    endtask

    task automatic t_idcode();
        logic [63:0] o;
        go_tlr_rti();
        scan_dr(32, 64'h0, o);
        chk(o[31:0] == IDX, "R1 id word after reset", 64'(o[31:0]), 64'(IDX));
    endtask

    task automatic t_ir_capture();
        logic [3:0] o;
        logic [63:0] d;
        scan_ir(4'b1111, o);
        chk(o == 4'b0001, "R2 IR capture pattern", 64'(o), 64'h1);
        scan_dr(8, 64'hB5, d);
        chk(d[7:0] == 8'h6A, "R2 new instruction active after update", 64'(d[7:0]), 64'h6A);
    endtask

    task automatic t_bypass();
        logic [3:0] o;
        logic [63:0] d;
        scan_ir(4'b1111, o);
        scan_dr(10, 64'h2D3, d);
        chk(d[9:0] == 10'h1A6, "R3 bypass one-bit delay", 64'(d[9:0]), 64'h1A6);
        scan_ir(4'b0101, o);
        chk(o == 4'b0001, "R2 capture on second scan", 64'(o), 64'h1);
        scan_dr(6, 64'h3F, d);
        chk(d[5:0] == 6'h3E, "R3 unsupported opcode acts as bypass", 64'(d[5:0]), 64'h3E);
    endtask

    logic [63:0] pre;

    task automatic t_sample();
        logic [3:0] o;
        logic [63:0] d, exp;
        pin_in = 6'b011010; sys_pin_out = 6'b110001; sys_pin_oe = 6'b010111;
        exp = '0;
        for (int i = 0; i < NP; i++) begin
            exp[3*i] = pin_in[i]; exp[3*i+1] = sys_pin_out[i]; exp[3*i+2] = sys_pin_oe[i];
        end
        pre = 64'h2_6A9C;
        scan_ir(4'b0010, o);
        scan_dr(CH, pre, d);
        chk(d[CH-1:0] == exp[CH-1:0], "R4 sample cell order", d, exp);
        #1;
        chk(pin_out == sys_pin_out && pin_oe == sys_pin_oe, "R4 pins unchanged by sample",
            64'({pin_out, pin_oe}), 64'({sys_pin_out, sys_pin_oe}));
    endtask

    task automatic t_extest();
        logic [3:0] o;
        logic [63:0] d, q, exp;
        logic [NP-1:0] eo, ee;
        scan_ir(4'b0000, o);
        #1;
        for (int i = 0; i < NP; i++) begin eo[i] = pre[3*i+1]; ee[i] = pre[3*i+2]; end
        chk(pin_out == eo && pin_oe == ee, "R5 extest drives preload at once",
            64'({pin_out, pin_oe}), 64'({eo, ee}));
        q = 64'h1_B5C3;
        scan_dr(CH, q, d);
        exp = '0;
        for (int i = 0; i < NP; i++) begin
            exp[3*i] = pin_in[i]; exp[3*i+1] = sys_pin_out[i]; exp[3*i+2] = sys_pin_oe[i];
        end
        chk(d[CH-1:0] == exp[CH-1:0], "R5 extest capture", d, exp);
        #1;
        for (int i = 0; i < NP; i++) begin eo[i] = q[3*i+1]; ee[i] = q[3*i+2]; end
        chk(pin_out == eo && pin_oe == ee, "R5 extest update drives pins",
            64'({pin_out, pin_oe}), 64'({eo, ee}));
    endtask

    task automatic t_sysreset();
        logic [3:0] o;
        logic [63:0] d;
        scan_ir(4'b1100, o);
        #1;
        chk(pin_out == sys_pin_out && pin_oe == sys_pin_oe, "R6 pins back to system",
            64'({pin_out, pin_oe}), 64'({sys_pin_out, sys_pin_oe}));
        scan_dr(1, 64'h1, d);
        #1;
        chk(sys_rst_req == 1'b1, "R6 reset request raised", 64'(sys_rst_req), 1);
        chk(pin_oe == '0 && pin_out == '0, "R7 pins high-z in reset", 64'({pin_out, pin_oe}), 0);
        scan_ir(4'b1111, o);
        go_tlr_rti();
        #1;
        chk(sys_rst_req == 1'b1, "R6 request held across instructions", 64'(sys_rst_req), 1);
        chk(pin_oe == '0, "R7 high-z under idcode in reset", 64'(pin_oe), 0);
        scan_ir(4'b1100, o);
        scan_dr(1, 64'h0, d);
        #1;
        chk(d[0] == 1'b1, "R6 capture returns current bit", 64'(d[0]), 1);
        chk(sys_rst_req == 1'b0, "R6 request cleared by zero", 64'(sys_rst_req), 0);
    endtask

    task automatic t_ext_reset();
        logic [3:0] o;
        logic [NP-1:0] eo, ee;
        ext_reset = 1'b1;
        #1;
        chk(pin_oe == '0 && pin_out == '0, "R7 external reset high-z", 64'({pin_out, pin_oe}), 0);
        scan_ir(4'b0000, o);
        #1;
        for (int i = 0; i < NP; i++) begin eo[i] = 64'h1_B5C3 >> (3*i+1); ee[i] = 64'h1_B5C3 >> (3*i+2); end
        chk(pin_out == eo && pin_oe == ee, "R7 extest overrides reset high-z",
            64'({pin_out, pin_oe}), 64'({eo, ee}));
        ext_reset = 1'b0;
        go_tlr_rti();
    endtask

    task automatic t_tdo_timing();
        logic x, v0, v1;
        tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
        #1;
        chk(tdo_oe == 1'b0, "R9 enable waits for falling edge", 64'(tdo_oe), 0);
        @(negedge tck); #1;
        chk(tdo_oe == 1'b1, "R9 enable in shift", 64'(tdo_oe), 1);
        v0 = tdo; tms = 0; tdi = 0;
        @(posedge tck); #1;
        v1 = tdo;
        chk(v1 == v0 && v0 == IDX[0], "R9 tdo stable across rising edge", 64'(v1), 64'(IDX[0]));
        @(negedge tck); #1;
        chk(tdo == IDX[1], "R9 tdo next bit on falling edge", 64'(tdo), 64'(IDX[1]));
        tms = 1;
        @(posedge tck);
        tick(1, 0, x); tick(0, 0, x);
        @(negedge tck); #1;
        chk(tdo_oe == 1'b0, "R9 enable off outside shift", 64'(tdo_oe), 0);
    endtask

    task automatic t_tms_reset();
        logic [3:0] o;
        logic [63:0] d;
        logic x;
        scan_ir(4'b1111, o);
        tick(1, 0, x); tick(0, 0, x); tick(0, 0, x); tick(1, 0, x); tick(0, 0, x);
        for (int i = 0; i < 5; i++) tick(1, 0, x);
        tick(0, 0, x);
        scan_dr(32, 64'h0, d);
        chk(d[31:0] == IDX, "R10 five TMS ones reach reset", 64'(d[31:0]), 64'(IDX));
    endtask

    task automatic t_disable();
        logic [3:0] o;
        logic [63:0] d;
        logic x;
        scan_ir(4'b1100, o);
        scan_dr(1, 64'h1, d);
        jtag_dis = 1'b1;
        tick(1, 0, x); tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
        @(negedge tck); #1;
        chk(tdo_oe == 1'b0, "R8 no tdo drive when disabled", 64'(tdo_oe), 0);
        chk(sys_rst_req == 1'b0, "R8 reset register cleared", 64'(sys_rst_req), 0);
        jtag_dis = 1'b0; fuse_prog = 1'b0;
        tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
        @(negedge tck); #1;
        chk(tdo_oe == 1'b0, "R8 unprogrammed fuse blocks port", 64'(tdo_oe), 0);
        fuse_prog = 1'b1;
        tick(0, 0, x);
        scan_dr(32, 64'h0, d);
        chk(d[31:0] == IDX, "R8 idcode after re-enable", 64'(d[31:0]), 64'(IDX));
    endtask

    initial begin
        t_reset_state();
        t_idcode();
        t_ir_capture();
        t_bypass();
        t_sample();
        t_extest();
        t_sysreset();
        t_ext_reset();
        t_tdo_timing();
        t_tms_reset();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule